// File: doc/BRIEF.md
# Dual-Clock Queue with Read Rewind

This block is a first-in first-out queue whose write side and read side run on unrelated clocks. Words enter on the write clock and leave on the read clock. Each side keeps a binary pointer. A Gray-coded copy of each pointer passes to the other side through a two-flop synchronizer, and each side computes its own flag from its local pointer and the synchronized remote one.

Two straps are sampled while the master reset is held low and are then frozen. The first strap picks the output timing. In standard mode, a word appears on the output only after a read request. In first-word-fall-through mode, the head word is presented without any request. The second strap picks how fast a rewind takes effect.

A rewind request on the read clock sends the read pointer back to physical location 0, so the stored words can be read again from the start. With the rewind strap low, location 0 is on the output right after the requesting edge. With the strap high, it appears one read-clock cycle later.

Top module: `dcq_rt`

## Requirements
- R1: After a rewind, reads return the words starting from physical location 0 in write order: the word after location 0 is location 1.
- R2: With the rewind strap low, the word at location 0 is on `rd_data` at the first sample after the rewind edge. In first-word-fall-through mode, `rd_flag` is high at that sample.
- R3: With the rewind strap high, `rd_data` keeps its old value for the first cycle after the rewind edge. It shows location 0 one read-clock cycle later.
- R4: In standard mode, `wr_flag` is active-low full: it is 0 while the queue holds 2^AW words. A write while full is dropped and does not appear in later reads.
- R5: In first-word-fall-through mode, `wr_flag` is active-high full. It is 1 once 2^AW words sit in storage behind the presented word. A write while full is dropped.
- R6: In standard mode, `rd_flag` is 0 while the queue is empty. A read while empty leaves `rd_data` unchanged.
- R7: In first-word-fall-through mode, `rd_flag` goes high and the first word appears on `rd_data` without a read. Each read advances to the next word. `rd_flag` is 0 once the last word is consumed.
- R8: The straps are captured only while `mrst_n` is 0. Changing them afterwards has no effect on mode or rewind latency.
- R9: After master reset, `rd_flag` is 0 and `rd_data` is 0. `wr_flag` is 1 in standard mode and 0 in first-word-fall-through mode.
- R10: A rewind and a read on the same read-clock edge act as a rewind alone. The read is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low; straps are sampled while low |
| strap_fwft | input | 1 | 1 = first-word-fall-through, 0 = standard mode |
| strap_rt_slow | input | 1 | 1 = rewind takes one extra cycle, 0 = immediate |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| wr_flag | output | 1 | Full indication, polarity per mode |
| rd_en | input | 1 | Read request |
| rt_req | input | 1 | Rewind request |
| rd_data | output | DW | Output data register |
| rd_flag | output | 1 | Data-available indication (low = empty) |

## Verification
A rewind and an ordinary read can arrive on the same read-clock edge. The bench raises `rt_req` and `rd_en` together after the read pointer has already moved past location 0. It then expects location 0 on the output, not the next sequential word, and it expects the read after that to return location 1. A read that won the conflict would show up as location 1 appearing one read too early.

// File: rtl/dcq_rt.sv
module dcq_rt #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          strap_fwft,
  input  logic          strap_rt_slow,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_flag,
  input  logic          rd_en,
  input  logic          rt_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic          fwft_w;
  logic [PW-1:0] wbin, wgray, rsync1, rsync2, wbin_nx;
  logic          full;

  always_ff @(posedge wr_clk)
    if (!mrst_n) fwft_w <= strap_fwft;

  assign full    = wgray == {~rsync2[AW:AW-1], rsync2[AW-2:0]};
  assign wbin_nx = wbin + PW'(wr_en && !full);
  assign wr_flag = fwft_w ? full : ~full;

  always_ff @(posedge wr_clk or negedge mrst_n)
    if (!mrst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      rsync1 <= '0;
      rsync2 <= '0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wbin_nx ^ (wbin_nx >> 1);
      rsync1 <= rgray;
      rsync2 <= rsync1;
    end

  always_ff @(posedge wr_clk)
    if (wr_en && !full) mem[wbin[AW-1:0]] <= wr_data;

  // read domain
  logic          fwft_r, slow_r;
  logic [PW-1:0] rbin, rgray, wsync1, wsync2, rbin_nx;
  logic          empty, dvalid, valid_nx, pend, pend_nx, ld;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] dout;

  always_ff @(posedge rd_clk)
    if (!mrst_n) begin
      fwft_r <= strap_fwft;
      slow_r <= strap_rt_slow;
    end

  assign empty = rgray == wsync2;

  always_comb begin
    rbin_nx  = rbin;
    ld       = 1'b0;
    ld_addr  = rbin[AW-1:0];
    valid_nx = dvalid;
    pend_nx  = 1'b0;
    if (rt_req) begin
      if (slow_r) begin
        rbin_nx = '0;
        pend_nx = 1'b1;
        if (fwft_r) valid_nx = 1'b0;
      end else begin
        ld      = 1'b1;
        ld_addr = '0;
        rbin_nx = PW'(1);
        if (fwft_r) valid_nx = 1'b1;
      end
    end else if (pend && !fwft_r) begin
      ld      = 1'b1;
      ld_addr = '0;
      rbin_nx = PW'(1);
    end else if (fwft_r) begin
      if (!empty && (!dvalid || rd_en)) begin
        ld       = 1'b1;
        rbin_nx  = rbin + PW'(1);
        valid_nx = 1'b1;
      end else if (rd_en) begin
        valid_nx = 1'b0;
      end
    end else if (rd_en && !empty) begin
      ld      = 1'b1;
      rbin_nx = rbin + PW'(1);
    end
  end

  always_ff @(posedge rd_clk or negedge mrst_n)
    if (!mrst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wsync1 <= '0;
      wsync2 <= '0;
      dvalid <= 1'b0;
      pend   <= 1'b0;
      dout   <= '0;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= rbin_nx ^ (rbin_nx >> 1);
      wsync1 <= wgray;
      wsync2 <= wsync1;
      dvalid <= valid_nx;
      pend   <= pend_nx;
      if (ld) dout <= mem[ld_addr];
    end

  assign rd_data = dout;
  assign rd_flag = fwft_r ? dvalid : ~empty;
endmodule

// File: rtl/dcq_rt_chk.sv
module dcq_rt_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          mrst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rt_req,
  input logic          wr_flag,
  input logic          rd_flag,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic          fwft_w,
  input logic          fwft_r,
  input logic          slow_r,
  input logic          pend
);
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    ((fwft_w ? wr_flag : !wr_flag) && wr_en) |=> $stable(wbin)); // R4 R5

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    (!fwft_r && !rd_flag && rd_en && !rt_req && !pend) |=> ($stable(rbin) && $stable(rd_data))); // R6

  AST_RT_REWIND: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    rt_req |=> (rbin == (slow_r ? '0 : (AW+1)'(1)))); // R1 R10

  AST_RT_SLOW_HOLD: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    (rt_req && slow_r && !fwft_r) |=> $stable(rd_data)); // R3

  AST_FWFT_HOLD: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    (fwft_r && rd_flag && !rd_en && !rt_req) |=> (rd_flag && $stable(rd_data))); // R7

  AST_STRAP_FROZEN_W: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    mrst_n |=> $stable(fwft_w)); // R8

  AST_STRAP_FROZEN_R: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    mrst_n |=> ($stable(fwft_r) && $stable(slow_r))); // R8
endmodule

bind dcq_rt dcq_rt_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/tb_dcq_rt.sv
module tb_dcq_rt;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, mrst_n = 0;
  logic strap_fwft = 0, strap_rt_slow = 0;
  logic wr_en = 0, rd_en = 0, rt_req = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_flag, rd_flag;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];

  dcq_rt #(.DW(DW), .AW(AW)) dut (.*);

  always #4 wr_clk = ~wr_clk;
  initial begin #3; forever #4 rd_clk = ~rd_clk; end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic f, input logic s);
    mrst_n = 0; strap_fwft = f; strap_rt_slow = s;
    repeat (5) @(negedge wr_clk);
    mrst_n = 1;
    @(negedge wr_clk);
    strap_fwft = ~f; strap_rt_slow = ~s;   // R8: must be ignored from here on
    exp_q.delete();
  endtask

  task automatic push_word(input logic [DW-1:0] d, input bit keep);
    @(negedge wr_clk) begin wr_en = 1; wr_data = d; end
    @(negedge wr_clk) wr_en = 0;
    if (keep) exp_q.push_back(d);
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic pop_std(input string req);
    logic [DW-1:0] e;
    @(negedge rd_clk) rd_en = 1;
    @(negedge rd_clk) rd_en = 0;
    e = exp_q.pop_front();
    check(req, rd_data, e);
  endtask

  task automatic pop_fwft(input string req);
    logic [DW-1:0] e;
    @(negedge rd_clk);
    e = exp_q.pop_front();
    check(req, rd_flag, 1);
    check(req, rd_data, e);
    rd_en = 1;
    @(negedge rd_clk) rd_en = 0;
  endtask

  task automatic rewind(input bit with_read);
    @(negedge rd_clk) begin rt_req = 1; rd_en = with_read; end
    @(negedge rd_clk) begin rt_req = 0; rd_en = 0; end
  endtask

  initial begin
    // standard mode, immediate rewind
    do_reset(0, 0);
    check("R9 wr_flag std", wr_flag, 1);
    check("R9 rd_flag", rd_flag, 0);
    check("R9 rd_data", rd_data, 0);
    check("R8 mode kept std", wr_flag, 1);
    @(negedge rd_clk) rd_en = 1;
    @(negedge rd_clk) rd_en = 0;
    check("R6 read while empty", rd_data, 0);
    check("R6 empty flag", rd_flag, 0);
    for (int i = 0; i < 5; i++) push_word(8'hA0 + 8'(i), 1);
    settle();
    check("R6 not empty", rd_flag, 1);
    for (int i = 0; i < 3; i++) pop_std("R6 ordered read");
    rewind(0);
    check("R2 loc0 at once", rd_data, 8'hA0);
    exp_q = {8'hA1, 8'hA2, 8'hA3, 8'hA4};
    pop_std("R1 after rewind");
    rewind(1);
    check("R10 rewind beats read", rd_data, 8'hA0);
    exp_q = {8'hA1, 8'hA2};
    pop_std("R10 next is loc1");
    pop_std("R1 loc2");

    // standard mode fill
    do_reset(0, 0);
    for (int i = 0; i < DEPTH; i++) push_word(8'h10 + 8'(i), 1);
    @(negedge wr_clk);
    check("R4 full low", wr_flag, 0);
    push_word(8'hEE, 0);
    settle();
    for (int i = 0; i < DEPTH; i++) pop_std("R4 data after full");
    check("R6 empty after drain", rd_flag, 0);
    @(negedge rd_clk) rd_en = 1;
    @(negedge rd_clk) rd_en = 0;
    check("R4 dropped word absent", rd_data, 8'h10 + 8'(DEPTH - 1));
    repeat (8) @(negedge wr_clk);
    check("R4 full released", wr_flag, 1);

    // standard mode, one-cycle rewind, straps flipped after reset
    do_reset(0, 1);
    check("R8 std after strap flip", wr_flag, 1);
    for (int i = 0; i < 3; i++) push_word(8'h50 + 8'(i), 1);
    settle();
    pop_std("R3 pre read");
    pop_std("R3 pre read");
    @(negedge rd_clk) rt_req = 1;
    @(negedge rd_clk) rt_req = 0;
    check("R3 output held", rd_data, 8'h51);
    @(negedge rd_clk);
    check("R3 loc0 one cycle later", rd_data, 8'h50);
    exp_q = {8'h51, 8'h52};
    pop_std("R1 slow rewind order");

    // fall-through mode, immediate rewind
    do_reset(1, 0);
    check("R9 wr_flag fwft", wr_flag, 0);
    check("R9 rd_flag fwft", rd_flag, 0);
    for (int i = 0; i < 3; i++) push_word(8'h70 + 8'(i), 1);
    settle();
    check("R7 word without read", rd_data, 8'h70);
    for (int i = 0; i < 3; i++) pop_fwft("R7 advance");
    @(negedge rd_clk);
    check("R7 empty flag", rd_flag, 0);
    rewind(0);
    check("R2 fwft loc0", rd_data, 8'h70);
    check("R2 fwft flag", rd_flag, 1);
    exp_q = {8'h70, 8'h71, 8'h72};
    pop_fwft("R1 fwft rewind");
    pop_fwft("R1 fwft rewind");

    // fall-through fill
    do_reset(1, 0);
    for (int i = 0; i < DEPTH + 1; i++) push_word(8'h20 + 8'(i), 1);
    repeat (8) @(negedge wr_clk);
    check("R5 full high", wr_flag, 1);
    push_word(8'hEE, 0);
    for (int i = 0; i < DEPTH + 1; i++) pop_fwft("R5 data after full");
    @(negedge rd_clk);
    check("R5 dropped word absent", rd_flag, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule